// File: doc/BRIEF.md
# Processor Address Bus Generator

This block forms every address that an N-bit-data, M-bit-address processor puts on its memory bus. It holds a program counter twice the data width, split into a low and a high half, an internal memory address register of the same width that software cannot see, and a data-width stack pointer. Each cycle, a source select chooses which of five address forms drives the bus. The forms are the program counter, the memory address register, the stack slot, a zero-page address taken from the data input, and the fixed interrupt vector.

The sequencer drives the strobes: half loads from the data input, program counter increment, and stack pointer load, push and pop. The stack page and the interrupt vector are not stored anywhere. They come from the data width alone: the stack page sits at `1 << N` and the vector just above it at `2 << N`. Both wider registers are cut to their M low bits on the bus. The parameters must satisfy an even N of at least 8 and N+2 <= M <= 2N, and elaboration stops otherwise.

Top module: `addr_gen_top`

## Requirements
- R1: A synchronous active-high reset clears the program counter, the memory address register and the bus output to 0, and sets the stack pointer to all ones.
- R2: The bus output is registered. After a clock edge it shows the source that `src_sel` selected at that edge, built from register values before that edge's updates. The `src_sel` codes are: 0 program counter, 1 memory address register, 2 stack slot, 3 zero page, 4 interrupt vector. Codes 5 to 7 drive all zeros.
- R3: Program counter increment adds one across the full 2N bits, so a low half of all ones carries into the high half.
- R4: `pc_ld_lo` and `pc_ld_hi` load the low half (bits N-1:0) and the high half (bits 2N-1:N) from `din`. Any program counter load takes priority over an increment in the same cycle.
- R5: The program counter drives only its M least significant bits onto the bus.
- R6: `mar_ld_lo` and `mar_ld_hi` load the low and high halves of the memory address register from `din`. The bus shows its M least significant bits.
- R7: The stack slot address is `(1 << N) | sp`, which with N=8 covers 0x100 to 0x1FF.
- R8: Push decrements the stack pointer after the current slot is addressed, and pop increments it. Both wrap within N bits. Load from `din` beats both, and push together with pop leaves the pointer unchanged.
- R9: Zero page drives `din` on the low N bits with all upper bits 0.
- R10: The interrupt vector address is `2 << N`, the first address above the stack page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | DW | Data byte for loads and zero page |
| src_sel | input | 3 | Address source code |
| pc_ld_lo | input | 1 | Load program counter low half |
| pc_ld_hi | input | 1 | Load program counter high half |
| pc_inc | input | 1 | Increment program counter |
| mar_ld_lo | input | 1 | Load memory address register low half |
| mar_ld_hi | input | 1 | Load memory address register high half |
| sp_ld | input | 1 | Load stack pointer |
| sp_push | input | 1 | Push: decrement stack pointer |
| sp_pop | input | 1 | Pop: increment stack pointer |
| addr_out | output | AW | Registered address bus |

## Verification
The assertions check, on every cycle, the layout of the stack, zero-page and vector addresses and the step rules of the program counter and stack pointer. These include increment with carry, load priority over increment, and a push decrement that wraps. Only the bench's scenarios show the reset values, the truncation of wide registers to M bits, the half loads of the memory address register, and the all-zero output for unused codes. The same holds for push, pop and load ordering across a sequence, and the wrap of the stack pointer from 0 to all ones and back.

// File: rtl/addr_gen_pkg.sv
package addr_gen_pkg;
  typedef enum logic [2:0] {
    SRC_PC    = 3'd0,
    SRC_MAR   = 3'd1,
    SRC_STACK = 3'd2,
    SRC_ZPAGE = 3'd3,
    SRC_VEC   = 3'd4
  } addr_src_e;
endpackage

// File: rtl/ag_wide_reg.sv
// Double-width register built from two half-width halves, each loadable
// from the data byte; an optional full-width increment stays behind loads.
module ag_wide_reg #(
  parameter int HW      = 8,
  parameter bit HAS_INC = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld_lo,
  input  logic            ld_hi,
  input  logic            inc,
  input  logic [HW-1:0]   d,
  output logic [2*HW-1:0] q
);
  localparam int FW = 2 * HW;

  logic [FW-1:0] q_r;
  logic [FW-1:0] step;

  generate
    if (HAS_INC) begin : g_inc
      assign step = inc ? q_r + FW'(1) : q_r;
    end else begin : g_hold
      assign step = q_r;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      q_r <= '0;
    end else if (ld_lo || ld_hi) begin
      if (ld_lo) q_r[HW-1:0]  <= d;
      if (ld_hi) q_r[FW-1:HW] <= d;
    end else begin
      q_r <= step;
    end
  end

  assign q = q_r;
endmodule

// File: rtl/ag_stack_ptr.sv
// Data-width stack pointer: load, push (down) and pop (up), wrapping.
module ag_stack_ptr #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] sp
);
  logic [DW-1:0] sp_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_r <= '1;
    end else if (ld) begin
      sp_r <= d;
    end else if (push && !pop) begin
      sp_r <= sp_r - DW'(1);
    end else if (pop && !push) begin
      sp_r <= sp_r + DW'(1);
    end
  end

  assign sp = sp_r;
endmodule

// File: rtl/ag_addr_mux.sv
// Registered selector that forms the bus address from the chosen source.
module ag_addr_mux
  import addr_gen_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  addr_src_e       sel,
  input  logic [2*DW-1:0] pc,
  input  logic [2*DW-1:0] mar,
  input  logic [DW-1:0]   sp,
  input  logic [DW-1:0]   din,
  output logic [AW-1:0]   addr
);
  localparam logic [AW-1:0] STACK_BASE = AW'(1) << DW;
  localparam logic [AW-1:0] VEC_ADDR   = AW'(2) << DW;

  logic [AW-1:0] nxt;
  logic [AW-1:0] addr_r;

  always_comb begin
    unique case (sel)
      SRC_PC:    nxt = AW'(pc);
      SRC_MAR:   nxt = AW'(mar);
      SRC_STACK: nxt = STACK_BASE | AW'(sp);
      SRC_ZPAGE: nxt = AW'(din);
      SRC_VEC:   nxt = VEC_ADDR;
      default:   nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) addr_r <= '0;
    else     addr_r <= nxt;
  end

  assign addr = addr_r;
endmodule

// File: rtl/addr_gen_top.sv
module addr_gen_top
  import addr_gen_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] din,
  input  logic [2:0]    src_sel,
  input  logic          pc_ld_lo,
  input  logic          pc_ld_hi,
  input  logic          pc_inc,
  input  logic          mar_ld_lo,
  input  logic          mar_ld_hi,
  input  logic          sp_ld,
  input  logic          sp_push,
  input  logic          sp_pop,
  output logic [AW-1:0] addr_out
);
  localparam int FW = 2 * DW;

  generate
    if ((DW % 2) != 0 || DW < 8 || AW < DW + 2 || AW > FW) begin : g_bad_cfg
      $error("addr_gen_top: need even DW >= 8 and DW+2 <= AW <= 2*DW");
    end
  endgenerate

  logic [FW-1:0] pc_q;
  logic [FW-1:0] mar_q;
  logic [DW-1:0] sp_q;

  ag_wide_reg #(.HW(DW), .HAS_INC(1'b1)) i_pc (
    .clk(clk), .rst(rst), .ld_lo(pc_ld_lo), .ld_hi(pc_ld_hi),
    .inc(pc_inc), .d(din), .q(pc_q)
  );

  ag_wide_reg #(.HW(DW), .HAS_INC(1'b0)) i_mar (
    .clk(clk), .rst(rst), .ld_lo(mar_ld_lo), .ld_hi(mar_ld_hi),
    .inc(1'b0), .d(din), .q(mar_q)
  );

  ag_stack_ptr #(.DW(DW)) i_sp (
    .clk(clk), .rst(rst), .ld(sp_ld), .push(sp_push), .pop(sp_pop),
    .d(din), .sp(sp_q)
  );

  ag_addr_mux #(.DW(DW), .AW(AW)) i_mux (
    .clk(clk), .rst(rst), .sel(addr_src_e'(src_sel)),
    .pc(pc_q), .mar(mar_q), .sp(sp_q), .din(din), .addr(addr_out)
  );
endmodule

// File: rtl/addr_gen_chk.sv
module addr_gen_chk #(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input logic            clk,
  input logic            rst,
  input logic [DW-1:0]   din,
  input logic [2:0]      src_sel,
  input logic            pc_ld_lo,
  input logic            pc_ld_hi,
  input logic            pc_inc,
  input logic            sp_ld,
  input logic            sp_push,
  input logic            sp_pop,
  input logic [AW-1:0]   addr_out,
  input logic [2*DW-1:0] pc_val,
  input logic [DW-1:0]   sp_val
);
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R7
  stack_page_chk: assert property (@(posedge clk) disable iff (rst)
    armed && $past(src_sel) == 3'd2 |-> addr_out == ((AW'(1) << DW) | AW'($past(sp_val))));

  // R10
  vector_chk: assert property (@(posedge clk) disable iff (rst)
    armed && $past(src_sel) == 3'd4 |-> addr_out == (AW'(2) << DW));

  // R9
  zpage_chk: assert property (@(posedge clk) disable iff (rst)
    armed && $past(src_sel) == 3'd3 |-> addr_out == AW'($past(din)));

  // R3
  pc_inc_chk: assert property (@(posedge clk) disable iff (rst)
    armed && $past(pc_inc && !pc_ld_lo && !pc_ld_hi) |-> pc_val == $past(pc_val) + 1'b1);

  // R4
  pc_ld_chk: assert property (@(posedge clk) disable iff (rst)
    armed && $past(pc_ld_lo) |-> pc_val[DW-1:0] == $past(din));

  // R8
  sp_push_chk: assert property (@(posedge clk) disable iff (rst)
    armed && $past(sp_push && !sp_pop && !sp_ld) |-> sp_val == DW'($past(sp_val) - 1'b1));
endmodule

bind addr_gen_top addr_gen_chk #(.DW(DW), .AW(AW)) i_chk (
  .clk(clk), .rst(rst), .din(din), .src_sel(src_sel),
  .pc_ld_lo(pc_ld_lo), .pc_ld_hi(pc_ld_hi), .pc_inc(pc_inc),
  .sp_ld(sp_ld), .sp_push(sp_push), .sp_pop(sp_pop),
  .addr_out(addr_out), .pc_val(pc_q), .sp_val(sp_q)
);

// File: tb/test_addr_gen_top.sv
module test_addr_gen_top;
  localparam int DW = 8;
  localparam int AW = 12;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DW-1:0] din = '0;
  logic [2:0] src_sel = '0;
  logic pc_ld_lo = 0, pc_ld_hi = 0, pc_inc = 0;
  logic mar_ld_lo = 0, mar_ld_hi = 0;
  logic sp_ld = 0, sp_push = 0, sp_pop = 0;
  logic [AW-1:0] addr_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [AW-1:0] exp_q[$];
  string tag_q[$];

  logic [2*DW-1:0] m_pc = '0;
  logic [2*DW-1:0] m_mar = '0;
  logic [DW-1:0] m_sp = '1;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_gen_top #(.DW(DW), .AW(AW)) i_addr_gen_top (
    .clk(clk), .rst(rst), .din(din), .src_sel(src_sel),
    .pc_ld_lo(pc_ld_lo), .pc_ld_hi(pc_ld_hi), .pc_inc(pc_inc),
    .mar_ld_lo(mar_ld_lo), .mar_ld_hi(mar_ld_hi),
    .sp_ld(sp_ld), .sp_push(sp_push), .sp_pop(sp_pop),
    .addr_out(addr_out)
  );

  // monitor: compare results one negedge after the edge that made them
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [AW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (addr_out !== e) begin
        bad++;
        $display("FAIL %s: addr_out=%h expected=%h", t, addr_out, e);
      end
    end
  end

  function automatic logic [AW-1:0] model_addr(input logic [2:0] s, input logic [DW-1:0] d);
    case (s)
      3'd0: return m_pc[AW-1:0];
      3'd1: return m_mar[AW-1:0];
      3'd2: return (AW'(1) << DW) | AW'(m_sp);
      3'd3: return AW'(d);
      3'd4: return AW'(2) << DW;
      default: return '0;
    endcase
  endfunction

  task automatic op(input logic [2:0] s, input logic [DW-1:0] d,
                    input bit pll, input bit plh, input bit pci,
                    input bit mll, input bit mlh,
                    input bit spl, input bit spu, input bit spo,
                    input string tag);
    logic [AW-1:0] e;
    @(negedge clk);
    src_sel = s; din = d;
    pc_ld_lo = pll; pc_ld_hi = plh; pc_inc = pci;
    mar_ld_lo = mll; mar_ld_hi = mlh;
    sp_ld = spl; sp_push = spu; sp_pop = spo;
    e = model_addr(s, d);
    if (pll || plh) begin
      if (pll) m_pc[DW-1:0] = d;
      if (plh) m_pc[2*DW-1:DW] = d;
    end else if (pci) m_pc = m_pc + 1'b1;
    if (mll) m_mar[DW-1:0] = d;
    if (mlh) m_mar[2*DW-1:DW] = d;
    if (spl) m_sp = d;
    else if (spu && !spo) m_sp = m_sp - 1'b1;
    else if (spo && !spu) m_sp = m_sp + 1'b1;
    @(posedge clk);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    total++;
    if (addr_out !== '0) begin
      bad++;
      $display("FAIL R1: reset addr_out=%h expected=%h", addr_out, {AW{1'b0}});
    end
    rst = 1'b0;
    //  src   din    pll plh pci mll mlh spl spu spo
    op(3'd0, 8'h00, 0, 0, 1, 0, 0, 0, 0, 0, "R1 pc reset");
    op(3'd0, 8'h00, 0, 0, 1, 0, 0, 0, 0, 0, "R3 pc step");
    op(3'd2, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0, "R1 sp reset R7");
    op(3'd0, 8'hFF, 1, 0, 0, 0, 0, 0, 0, 0, "R4 load lo");
    op(3'd0, 8'h12, 0, 1, 1, 0, 0, 0, 0, 0, "R4 load beats inc");
    op(3'd0, 8'h00, 0, 0, 1, 0, 0, 0, 0, 0, "R5 pc truncation");
    op(3'd0, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0, "R3 carry into high");
    op(3'd1, 8'h34, 0, 0, 0, 1, 0, 0, 0, 0, "R1 mar reset");
    op(3'd1, 8'hAB, 0, 0, 0, 0, 1, 0, 0, 0, "R6 mar lo");
    op(3'd1, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0, "R6 mar truncation");
    op(3'd2, 8'h00, 0, 0, 0, 0, 0, 0, 1, 0, "R8 push 1");
    op(3'd2, 8'h00, 0, 0, 0, 0, 0, 0, 1, 0, "R8 push 2");
    op(3'd2, 8'h00, 0, 0, 0, 0, 0, 0, 0, 1, "R8 pop");
    op(3'd2, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0, "R8 after pop");
    op(3'd2, 8'h00, 0, 0, 0, 0, 0, 1, 1, 0, "R8 load beats push");
    op(3'd2, 8'h00, 0, 0, 0, 0, 0, 0, 1, 0, "R7 slot at base");
    op(3'd2, 8'h00, 0, 0, 0, 0, 0, 0, 0, 1, "R8 wrap down");
    op(3'd2, 8'h00, 0, 0, 0, 0, 0, 0, 1, 1, "R8 wrap up");
    op(3'd2, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0, "R8 push with pop");
    op(3'd3, 8'h3A, 0, 0, 0, 0, 0, 0, 0, 0, "R9 zero page");
    op(3'd3, 8'hFF, 0, 0, 0, 0, 0, 0, 0, 0, "R9 zero page max");
    op(3'd4, 8'h55, 0, 0, 0, 0, 0, 0, 0, 0, "R10 vector");
    op(3'd7, 8'h55, 0, 0, 0, 0, 0, 0, 0, 0, "R2 unused code");
    op(3'd5, 8'h00, 0, 0, 1, 0, 0, 0, 0, 0, "R2 unused code 5");
    op(3'd0, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0, "R2 registered pc");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule